// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block sits beside a memory controller's command path and turns a programmed mode word into the column addresses of each data burst. A load strobe writes the base mode word when the accompanying bank select is zero; the stored word is decoded into a burst length, an ordering type and a read latency, and any reserved or unsupported combination is flagged as a mode error.

A burst-start strobe presents an 8-bit starting column. From the following cycle the block drives the column of the current beat, and each advance strobe steps to the next beat. Fixed bursts of 2, 4 or 8 beats keep their upper column bits and wrap the low bits inside their aligned block, either by adding the beat index (sequential order) or by XOR-ing it in (interleaved order). A full-page burst walks all 256 columns, upward or downward depending on bit 0 of the starting column, and runs until it is terminated or replaced by a new burst. The same ordering serves read and write bursts alike.

Top module: `burst_col_seq`

## Requirements
- R1: After reset the stored mode word is all zeros, so burst_len_o and cas_lat_o read 0, mode_err_o is 1 and valid_o is 0.
- R2: Mode bits 2..0 select the burst length shown on burst_len_o: 001 gives 2, 010 gives 4, 011 gives 8, 111 gives 256 (full page); any other code shows 0 and sets mode_err_o.
- R3: Mode bit 3 gives the order on burst_type_o: 0 is sequential, 1 is interleaved.
- R4: Mode bits 6..4 select cas_lat_o: 010 gives 2, 011 gives 3; any other code shows 0 and sets mode_err_o.
- R5: A load writes the stored word only when mode_bank_i is 0, with effect on the outputs from the next cycle; a load with any other bank value leaves every mode output unchanged.
- R6: Full page with interleaved order sets mode_err_o; so does any 1 in mode bit 7 or in bits 9 and up, while bit 8 has no effect.
- R7: While mode_err_o is 1 a burst-start strobe is ignored: an idle sequencer stays idle and a running burst continues unchanged.
- R8: An accepted burst start raises valid_o in the next cycle with col_o equal to the starting column; each advance moves col_o to the next beat in the next cycle.
- R9: In sequential order with length L of 2, 4 or 8, beat k drives the upper bits of the start unchanged and (start + k) mod L on the low log2(L) bits.
- R10: In interleaved order with length L of 2, 4 or 8, beat k drives the upper bits unchanged and start XOR k on the low log2(L) bits.
- R11: In full page, beat k is (start + k) mod 256 when start bit 0 is 0 and (start - k) mod 256 when it is 1; last_o stays 0 and the burst keeps running.
- R12: last_o is 1 exactly on beat L-1 of a fixed-length burst; an advance on that beat drops valid_o in the next cycle.
- R13: terminate_i ends a running burst (valid_o 0 in the next cycle); an accepted burst start takes priority over advance and terminate and restarts from its own column.
- R14: A burst keeps the length and order it started with; a mode load during the burst changes the mode outputs but not the running column sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_mode_i | input | 1 | Mode load strobe |
| mode_bank_i | input | BANK_W (2) | Bank select of the load; only 0 writes the base word |
| mode_addr_i | input | MODE_W (11) | Mode word carried on the address bus |
| burst_start_i | input | 1 | Burst start strobe |
| start_col_i | input | COL_W (8) | Starting column of the burst |
| advance_i | input | 1 | Step to the next beat |
| terminate_i | input | 1 | End the running burst |
| col_o | output | COL_W (8) | Column of the current beat |
| valid_o | output | 1 | A burst is running and col_o is meaningful |
| last_o | output | 1 | Current beat is the final one of a fixed burst |
| burst_len_o | output | COL_W+1 (9) | Decoded burst length, 0 when reserved |
| burst_type_o | output | 1 | 0 sequential, 1 interleaved |
| cas_lat_o | output | 2 | Decoded read latency, 0 when reserved |
| mode_err_o | output | 1 | Stored mode word is reserved or unsupported |

## Verification
The bench builds the block with its defaults: an 8-bit column, an 11-bit mode word and a 2-bit bank select. With the 8-bit column, wrap at both ends of the full page (0xFF to 0x00 upward, 0x00 to 0xFF downward) is reached within a few beats, and every fixed length keeps upper column bits that the bench can see held still. The 11-bit word reaches the operating-mode bits, so the one ignored bit and the reserved ones can both be driven.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    typedef enum logic [2:0] {
        BLEN_NONE,
        BLEN_2,
        BLEN_4,
        BLEN_8,
        BLEN_PAGE
    } blen_e;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_XOR = 1'b1
    } order_e;

    typedef struct packed {
        blen_e      blen;
        order_e     order;
        logic [1:0] cas;
        logic       err;
    } mode_t;

    localparam int unsigned MW_BL_LSB  = 0;
    localparam int unsigned MW_BT_BIT  = 3;
    localparam int unsigned MW_CL_LSB  = 4;
    localparam int unsigned MW_OP_LSB  = 7;
    localparam int unsigned MW_DLL_BIT = 8;

    function automatic blen_e decode_blen(input logic [2:0] code);
        case (code)
            3'b001:  return BLEN_2;
            3'b010:  return BLEN_4;
            3'b011:  return BLEN_8;
            3'b111:  return BLEN_PAGE;
            default: return BLEN_NONE;
        endcase
    endfunction

    function automatic logic [1:0] decode_cas(input logic [2:0] code);
        case (code)
            3'b010:  return 2'd2;
            3'b011:  return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

    function automatic int unsigned blen_log2(input blen_e b);
        case (b)
            BLEN_2:  return 1;
            BLEN_4:  return 2;
            BLEN_8:  return 3;
            default: return 0;
        endcase
    endfunction

    function automatic mode_t decode_mode(input logic [6:0] low, input logic op_bad);
        mode_t m;
        m.blen  = decode_blen(low[MW_BL_LSB +: 3]);
        m.order = order_e'(low[MW_BT_BIT]);
        m.cas   = decode_cas(low[MW_CL_LSB +: 3]);
        m.err   = (m.blen == BLEN_NONE) || (m.cas == 2'd0) ||
                  ((m.blen == BLEN_PAGE) && (m.order == ORD_XOR)) || op_bad;
        return m;
    endfunction

endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg
    import bcs_pkg::*;
#(
    parameter int unsigned MODE_W = 11,
    parameter int unsigned BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [MODE_W-1:0] word_i,
    output mode_t             mode_o
);

    localparam int unsigned OP_W = MODE_W - MW_OP_LSB;
    localparam logic [OP_W-1:0] OP_IGNORE = OP_W'(1) << (MW_DLL_BIT - MW_OP_LSB);

    logic [MODE_W-1:0] word_q;
    logic              base_sel;
    logic              op_bad;

    assign base_sel = (bank_i == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (load_i && base_sel) begin
            word_q <= word_i;
        end
    end

    assign op_bad = |(word_q[MODE_W-1:MW_OP_LSB] & ~OP_IGNORE);
    assign mode_o = decode_mode(word_q[6:0], op_bad);

    // R5: a load aimed at another bank must not disturb the decoded mode
    assert_bank_guard_R5: assert property (@(posedge clk) disable iff (rst)
        (load_i && !base_sel) |=> $stable(mode_o));

endmodule

// File: rtl/bcs_beat_ctrl.sv
module bcs_beat_ctrl
    import bcs_pkg::*;
#(
    parameter int unsigned COL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [COL_W-1:0] col_i,
    input  logic             adv_i,
    input  logic             term_i,
    input  blen_e            blen_i,
    input  order_e           order_i,
    input  logic             err_i,
    output logic             active_o,
    output logic [COL_W-1:0] beat_o,
    output logic [COL_W-1:0] base_o,
    output blen_e            blen_o,
    output order_e           order_o,
    output logic             last_o
);

    logic             accept;
    logic [COL_W-1:0] final_beat;

    assign accept = start_i && !err_i;

    always_comb begin
        case (blen_o)
            BLEN_2:  final_beat = COL_W'(1);
            BLEN_4:  final_beat = COL_W'(3);
            BLEN_8:  final_beat = COL_W'(7);
            default: final_beat = '0;
        endcase
    end

    assign last_o = active_o && (blen_o != BLEN_PAGE) && (beat_o == final_beat);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_o <= 1'b0;
            beat_o   <= '0;
            base_o   <= '0;
            blen_o   <= BLEN_NONE;
            order_o  <= ORD_SEQ;
        end else if (accept) begin
            active_o <= 1'b1;
            beat_o   <= '0;
            base_o   <= col_i;
            blen_o   <= blen_i;
            order_o  <= order_i;
        end else if (active_o) begin
            if (term_i) begin
                active_o <= 1'b0;
            end else if (adv_i) begin
                if (last_o) begin
                    active_o <= 1'b0;
                end else begin
                    beat_o <= beat_o + COL_W'(1);
                end
            end
        end
    end

    // R7: a start seen under a mode error leaves an idle sequencer idle
    assert_err_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        (start_i && err_i && !active_o) |=> !active_o);

    // R7: a start seen under a mode error does not restart a running burst
    assert_err_keeps_R7: assert property (@(posedge clk) disable iff (rst)
        (start_i && err_i && active_o && !adv_i && !term_i) |=> $stable(beat_o) && $stable(base_o));

    // R12: advancing past the final beat ends the burst
    assert_last_ends_R12: assert property (@(posedge clk) disable iff (rst)
        (last_o && adv_i && !start_i) |=> !active_o);

    // R11: a full-page burst never flags a final beat
    assert_page_nolast_R11: assert property (@(posedge clk) disable iff (rst)
        (active_o && blen_o == BLEN_PAGE) |-> !last_o);

    // R13: terminate ends a running burst unless a start is accepted
    assert_term_R13: assert property (@(posedge clk) disable iff (rst)
        (active_o && term_i && !start_i) |=> !active_o);

endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen
    import bcs_pkg::*;
#(
    parameter int unsigned COL_W = 8
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  blen_e            blen_i,
    input  order_e           order_i,
    output logic [COL_W-1:0] mask_o,
    output logic [COL_W-1:0] col_o
);

    logic [COL_W-1:0] up_col;
    logic [COL_W-1:0] down_col;
    logic [COL_W-1:0] xor_col;
    logic [COL_W-1:0] wrap_col;

    for (genvar i = 0; i < COL_W; i++) begin : g_mask
        assign mask_o[i] = (blen_i == BLEN_PAGE) || (i < blen_log2(blen_i));
    end

    assign up_col   = base_i + beat_i;
    assign down_col = base_i - beat_i;
    assign xor_col  = base_i ^ beat_i;
    assign wrap_col = (order_i == ORD_XOR) ? xor_col : up_col;

    always_comb begin
        if (blen_i == BLEN_PAGE) begin
            col_o = base_i[0] ? down_col : up_col;
        end else begin
            col_o = (base_i & ~mask_o) | (wrap_col & mask_o);
        end
    end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int unsigned COL_W  = 8,
    parameter int unsigned MODE_W = 11,
    parameter int unsigned BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_mode_i,
    input  logic [BANK_W-1:0] mode_bank_i,
    input  logic [MODE_W-1:0] mode_addr_i,
    input  logic              burst_start_i,
    input  logic [COL_W-1:0]  start_col_i,
    input  logic              advance_i,
    input  logic              terminate_i,
    output logic [COL_W-1:0]  col_o,
    output logic              valid_o,
    output logic              last_o,
    output logic [COL_W:0]    burst_len_o,
    output logic              burst_type_o,
    output logic [1:0]        cas_lat_o,
    output logic              mode_err_o
);

    localparam int unsigned LEN_W = COL_W + 1;

    mode_t            mode;
    logic [COL_W-1:0] beat;
    logic [COL_W-1:0] base;
    logic [COL_W-1:0] mask;
    blen_e            run_blen;
    order_e           run_order;

    bcs_mode_reg #(
        .MODE_W (MODE_W),
        .BANK_W (BANK_W)
    ) u_mode (
        .clk    (clk),
        .rst    (rst),
        .load_i (load_mode_i),
        .bank_i (mode_bank_i),
        .word_i (mode_addr_i),
        .mode_o (mode)
    );

    bcs_beat_ctrl #(
        .COL_W (COL_W)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start_i  (burst_start_i),
        .col_i    (start_col_i),
        .adv_i    (advance_i),
        .term_i   (terminate_i),
        .blen_i   (mode.blen),
        .order_i  (mode.order),
        .err_i    (mode.err),
        .active_o (valid_o),
        .beat_o   (beat),
        .base_o   (base),
        .blen_o   (run_blen),
        .order_o  (run_order),
        .last_o   (last_o)
    );

    bcs_addr_gen #(
        .COL_W (COL_W)
    ) u_addr (
        .base_i  (base),
        .beat_i  (beat),
        .blen_i  (run_blen),
        .order_i (run_order),
        .mask_o  (mask),
        .col_o   (col_o)
    );

    always_comb begin
        case (mode.blen)
            BLEN_2:    burst_len_o = LEN_W'(2);
            BLEN_4:    burst_len_o = LEN_W'(4);
            BLEN_8:    burst_len_o = LEN_W'(8);
            BLEN_PAGE: burst_len_o = LEN_W'(1) << COL_W;
            default:   burst_len_o = '0;
        endcase
    end

    assign burst_type_o = mode.order;
    assign cas_lat_o    = mode.cas;
    assign mode_err_o   = mode.err;

    // R9 / R10: inside a fixed burst the bits above the block never move
    assert_upper_fixed_R9: assert property (@(posedge clk) disable iff (rst)
        (valid_o && $past(valid_o) && !$past(burst_start_i) && run_blen != BLEN_PAGE)
        |-> ((col_o & ~mask) == ($past(col_o) & ~mask)));

    // R8: an accepted start shows its own column in the next cycle
    assert_start_col_R8: assert property (@(posedge clk) disable iff (rst)
        (burst_start_i && !mode_err_o) |=> (valid_o && col_o == $past(start_col_i)));

    // R12: the final-beat flag only appears inside a running burst
    assert_last_valid_R12: assert property (@(posedge clk) disable iff (rst)
        last_o |-> valid_o);

endmodule

// File: tb/burst_col_seq_bench.sv
module burst_col_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_mode_i = 1'b0;
    logic [1:0]  mode_bank_i = '0;
    logic [10:0] mode_addr_i = '0;
    logic        burst_start_i = 1'b0;
    logic [7:0]  start_col_i = '0;
    logic        advance_i = 1'b0;
    logic        terminate_i = 1'b0;
    logic [7:0]  col_o;
    logic        valid_o;
    logic        last_o;
    logic [8:0]  burst_len_o;
    logic        burst_type_o;
    logic [1:0]  cas_lat_o;
    logic        mode_err_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    burst_col_seq u_burst_col_seq (
        .clk           (clk),
        .rst           (rst),
        .load_mode_i   (load_mode_i),
        .mode_bank_i   (mode_bank_i),
        .mode_addr_i   (mode_addr_i),
        .burst_start_i (burst_start_i),
        .start_col_i   (start_col_i),
        .advance_i     (advance_i),
        .terminate_i   (terminate_i),
        .col_o         (col_o),
        .valid_o       (valid_o),
        .last_o        (last_o),
        .burst_len_o   (burst_len_o),
        .burst_type_o  (burst_type_o),
        .cas_lat_o     (cas_lat_o),
        .mode_err_o    (mode_err_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic load(input logic [1:0] bank, input logic [10:0] word);
        @(negedge clk);
        load_mode_i = 1'b1; mode_bank_i = bank; mode_addr_i = word;
        @(negedge clk);
        load_mode_i = 1'b0; mode_bank_i = '0;
    endtask

    task automatic start(input logic [7:0] col);
        @(negedge clk);
        burst_start_i = 1'b1; start_col_i = col;
        @(negedge clk);
        burst_start_i = 1'b0;
    endtask

    task automatic step();
        advance_i = 1'b1;
        @(negedge clk);
        advance_i = 1'b0;
    endtask

    function automatic int exp_fixed(input int s, input int len, input bit xr, input int k);
        int blk = s - (s % len);
        if (xr) return blk + ((s % len) ^ k);
        return blk + ((s + k) % len);
    endfunction

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(burst_len_o == 0, "R1 len", burst_len_o, 0);
        chk(cas_lat_o == 0, "R1 cas", cas_lat_o, 0);
        chk(mode_err_o == 1, "R1 err", mode_err_o, 1);
        chk(valid_o == 0, "R1 valid", valid_o, 0);
    endtask

    task automatic t_decode();
        load(2'd0, 11'h023);
        chk(burst_len_o == 8, "R2 len8", burst_len_o, 8);
        chk(burst_type_o == 0, "R3 seq", burst_type_o, 0);
        chk(cas_lat_o == 2, "R4 cas2", cas_lat_o, 2);
        chk(mode_err_o == 0, "R2 noerr", mode_err_o, 0);
        load(2'd0, 11'h039);
        chk(burst_len_o == 2, "R2 len2", burst_len_o, 2);
        chk(burst_type_o == 1, "R3 xor", burst_type_o, 1);
        chk(cas_lat_o == 3, "R4 cas3", cas_lat_o, 3);
        load(2'd0, 11'h022);
        chk(burst_len_o == 4, "R2 len4", burst_len_o, 4);
        load(2'd0, 11'h037);
        chk(burst_len_o == 256, "R2 page", burst_len_o, 256);
        chk(mode_err_o == 0, "R2 page ok", mode_err_o, 0);
        load(2'd0, 11'h123);
        chk(mode_err_o == 0 && burst_len_o == 8, "R6 bit8 ignored", mode_err_o, 0);
    endtask

    task automatic t_bank_guard();
        load(2'd0, 11'h023);
        load(2'd1, 11'h025);
        chk(burst_len_o == 8 && mode_err_o == 0, "R5 bank1", burst_len_o, 8);
        load(2'd2, 11'h039);
        chk(burst_len_o == 8 && burst_type_o == 0 && cas_lat_o == 2, "R5 bank2", burst_len_o, 8);
    endtask

    task automatic t_reserved();
        load(2'd0, 11'h025);
        chk(burst_len_o == 0 && mode_err_o == 1, "R2 reserved len", burst_len_o, 0);
        start(8'h40);
        chk(valid_o == 0, "R7 start ignored", valid_o, 0);
        load(2'd0, 11'h013);
        chk(cas_lat_o == 0 && mode_err_o == 1, "R4 reserved cas", cas_lat_o, 0);
        load(2'd0, 11'h03F);
        chk(mode_err_o == 1, "R6 page xor", mode_err_o, 1);
        load(2'd0, 11'h0A3);
        chk(mode_err_o == 1, "R6 bit7", mode_err_o, 1);
        load(2'd0, 11'h423);
        chk(mode_err_o == 1, "R6 bit10", mode_err_o, 1);
    endtask

    task automatic t_fixed(input logic [10:0] word, input int s, input int len, input bit xr);
        load(2'd0, word);
        start(s[7:0]);
        for (int k = 0; k < len; k++) begin
            int e = exp_fixed(s, len, xr, k);
            chk(valid_o == 1, "R8 valid", valid_o, 1);
            chk(col_o == e[7:0], xr ? "R10 col" : "R9 col", col_o, e);
            chk(last_o == (k == len - 1), "R12 last", last_o, k == len - 1);
            step();
        end
        chk(valid_o == 0, "R12 end", valid_o, 0);
    endtask

    task automatic t_literal_xor();
        int unsigned exp_list [8] = '{5, 4, 7, 6, 1, 0, 3, 2};
        load(2'd0, 11'h03B);
        start(8'h05);
        for (int k = 0; k < 8; k++) begin
            chk(col_o == exp_list[k][7:0], "R10 literal", col_o, exp_list[k]);
            step();
        end
    endtask

    task automatic t_page(input logic [7:0] s, input bit down);
        load(2'd0, 11'h037);
        start(s);
        for (int k = 0; k < 6; k++) begin
            int e = down ? ((s - k + 256) % 256) : ((s + k) % 256);
            chk(col_o == e[7:0] && valid_o, "R11 page col", col_o, e);
            chk(last_o == 0, "R11 no last", last_o, 0);
            step();
        end
        @(negedge clk);
        terminate_i = 1'b1;
        @(negedge clk);
        terminate_i = 1'b0;
        chk(valid_o == 0, "R13 terminate", valid_o, 0);
    endtask

    task automatic t_restart();
        load(2'd0, 11'h023);
        start(8'h10);
        step();
        chk(col_o == 8'h11, "R8 step", col_o, 8'h11);
        burst_start_i = 1'b1; start_col_i = 8'h45; advance_i = 1'b1; terminate_i = 1'b1;
        @(negedge clk);
        burst_start_i = 1'b0; advance_i = 1'b0; terminate_i = 1'b0;
        chk(col_o == 8'h45 && valid_o, "R13 restart", col_o, 8'h45);
        step(); step(); step();
        chk(col_o == 8'h40, "R13 restart wrap", col_o, 8'h40);
        @(negedge clk);
        terminate_i = 1'b1;
        @(negedge clk);
        terminate_i = 1'b0;
    endtask

    task automatic t_midburst_mode();
        load(2'd0, 11'h023);
        start(8'h10);
        step(); step();
        load(2'd0, 11'h039);
        chk(burst_len_o == 2 && burst_type_o == 1, "R14 mode shown", burst_len_o, 2);
        for (int k = 2; k < 8; k++) begin
            chk(col_o == 8'(8'h10 + k), "R14 keeps order", col_o, 8'h10 + k);
            chk(last_o == (k == 7), "R14 keeps length", last_o, k == 7);
            step();
        end
        chk(valid_o == 0, "R14 end", valid_o, 0);
    endtask

    task automatic t_err_running();
        load(2'd0, 11'h023);
        start(8'h20);
        step(); step();
        load(2'd0, 11'h025);
        start(8'h77);
        chk(col_o == 8'h22 && valid_o, "R7 running kept", col_o, 8'h22);
        step();
        chk(col_o == 8'h23, "R7 continues", col_o, 8'h23);
        @(negedge clk);
        terminate_i = 1'b1;
        @(negedge clk);
        terminate_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_decode();
        t_bank_guard();
        t_reserved();
        t_fixed(11'h023, 8'h05, 8, 1'b0);
        t_fixed(11'h022, 8'h2E, 4, 1'b0);
        t_fixed(11'h039, 8'h81, 2, 1'b1);
        t_fixed(11'h03B, 8'h9C, 8, 1'b1);
        t_literal_xor();
        t_page(8'hFE, 1'b0);
        t_page(8'h01, 1'b1);
        t_restart();
        t_midburst_mode();
        t_err_running();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule